// File: doc/BRIEF.md
# Display Command/Data Byte Parser

This block sits behind a serial byte receiver in a small graphics display controller. Each received byte arrives with a select line. When the line is high, the byte is pixel data and goes straight to the frame store writer. When it is low, the byte belongs to a command stream. In that stream the first byte is an opcode. A fixed number of argument bytes follows, and the opcode sets how many.

The parser keeps a count of the argument bytes received for the command in progress. When the last argument arrives, it issues one of three actions:

- a column window load, with both bounds folded into 0..63;
- a row window load, with both bounds folded into 0..79;
- a load of the address-remap control byte.

Every other recognised opcode is swallowed together with its arguments. An opcode the parser does not know raises a one-cycle error pulse that carries the opcode. Data bytes may arrive in the middle of a command without cancelling it.

Every output is registered. A strobe appears in the cycle after the byte that caused it.

Top module: `cmd_byte_parser`

## Requirements
- R1: A byte accepted with `dataSel` high gives `dataStrobe` high for exactly the next cycle, with `dataByte` equal to that byte. No command strobe is raised.
- R2: The sequence 0x15, a, b in command mode gives one `colLoad` pulse after b, with `colStart` = a mod 64 and `colEnd` = b mod 64.
- R3: The sequence 0x75, a, b gives one `rowLoad` pulse after b, with `rowStart` = a mod 80 and `rowEnd` = b mod 80.
- R4: The sequence 0xA0, x gives one `remapLoad` pulse with `remapVal` = x.
- R5: The opcodes 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF each consume exactly one argument byte and raise no strobe. The byte after that argument is taken as a new opcode.
- R6: The opcodes 0x84–0x86, 0xA4–0xA7, 0xAE, 0xAF, 0xE3 and 0xFF consume no argument and raise no strobe.
- R7: Opcode 0xB8 consumes exactly eight argument bytes without acting on their values.
- R8: Any other opcode gives `errPulse` for one cycle, with `errOpcode` equal to that opcode. That opcode is treated as complete, so the next command byte is an opcode.
- R9: Data-mode bytes that arrive between the arguments of a command leave the command's progress unchanged. The command completes on its remaining command-mode bytes.
- R10: After reset all strobes are low, the column window is 0..63, the row window is 0..79, and the remap value is 0.
- R11: At most one of the five strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A received byte is present this cycle |
| dataSel | input | 1 | High: data byte; low: command byte |
| byteIn | input | 8 | Received byte |
| dataStrobe | output | 1 | Pixel byte pulse |
| dataByte | output | 8 | Pixel byte value |
| colLoad | output | 1 | Column window load pulse |
| colStart | output | 6 | Column window first address |
| colEnd | output | 6 | Column window last address |
| rowLoad | output | 1 | Row window load pulse |
| rowStart | output | 7 | Row window first address |
| rowEnd | output | 7 | Row window last address |
| remapLoad | output | 1 | Remap byte load pulse |
| remapVal | output | 8 | Remap control byte |
| errPulse | output | 1 | Unknown opcode pulse |
| errOpcode | output | 8 | Opcode that caused the error |

## Verification
The hardest state to reach from the ports is a command whose argument count is partly used up. At that point a byte's meaning depends on history that no output shows. The stimulus reaches it by interleaving data bytes between arguments, and by feeding argument bytes whose values are themselves valid opcodes (0x15, 0xA0). A following column or remap command then shows whether the counter consumed exactly the right number of bytes. The folded bounds are checked with argument values above 63 and above 79.

// File: rtl/cmd_byte_parser_pkg.sv
package cmd_byte_parser_pkg;
  localparam int BYTE_W   = 8;
  localparam int MAX_ARGS = 8;
  localparam int CNT_W    = $clog2(MAX_ARGS + 1);

  localparam logic [BYTE_W-1:0] OP_COL   = 8'h15;
  localparam logic [BYTE_W-1:0] OP_ROW   = 8'h75;
  localparam logic [BYTE_W-1:0] OP_REMAP = 8'hA0;

  typedef struct packed {
    logic known;
    logic [CNT_W-1:0] nArgs;
  } opInfo_t;

  typedef struct packed {
    logic passData;
    logic captureOp;
    logic captureArg;
    logic fireCol;
    logic fireRow;
    logic fireRemap;
    logic fireErr;
  } ctlStrobes_t;

  function automatic opInfo_t lookupOp(input logic [BYTE_W-1:0] op);
    opInfo_t r;
    r.known = 1'b1;
    r.nArgs = '0;
    case (op)
      8'h15, 8'h75: r.nArgs = CNT_W'(2);
      8'hA0, 8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
      8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF: r.nArgs = CNT_W'(1);
      8'hB8: r.nArgs = CNT_W'(MAX_ARGS);
      8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
      8'hAE, 8'hAF, 8'hE3, 8'hFF: r.nArgs = '0;
      default: r.known = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cmd_byte_parser_ctrl.sv
module cmd_byte_parser_ctrl
  import cmd_byte_parser_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic              dataSel,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic [BYTE_W-1:0] opcodeQ,
  output ctlStrobes_t       ctl
);
  logic [CNT_W-1:0] argCnt;
  logic [CNT_W-1:0] argCntD;
  opInfo_t          info;
  logic             isCmd;
  logic             lastArg;

  always_comb begin
    isCmd   = byteValid && !dataSel;
    info    = lookupOp((argCnt == '0) ? byteIn : opcodeQ);
    lastArg = (argCnt != '0) && (argCnt == info.nArgs);
    ctl     = '0;
    argCntD = argCnt;
    if (byteValid && dataSel) ctl.passData = 1'b1;
    if (isCmd) begin
      if (argCnt == '0) begin
        ctl.captureOp = 1'b1;
        ctl.fireErr   = !info.known;
        argCntD       = (info.known && info.nArgs != '0) ? CNT_W'(1) : '0;
      end else begin
        ctl.captureArg = 1'b1;
        if (lastArg) begin
          argCntD       = '0;
          ctl.fireCol   = (opcodeQ == OP_COL);
          ctl.fireRow   = (opcodeQ == OP_ROW);
          ctl.fireRemap = (opcodeQ == OP_REMAP);
        end else begin
          argCntD = argCnt + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) argCnt <= '0;
    else       argCnt <= argCntD;
  end
endmodule

// File: rtl/cmd_byte_parser_dp.sv
module cmd_byte_parser_dp
  import cmd_byte_parser_pkg::*;
#(
  parameter int COL_SPAN = 64,
  parameter int ROW_SPAN = 80,
  localparam int COL_W = $clog2(COL_SPAN),
  localparam int ROW_W = $clog2(ROW_SPAN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] byteIn,
  input  ctlStrobes_t       ctl,
  output logic [BYTE_W-1:0] opcodeQ,
  output logic              dataStrobe,
  output logic [BYTE_W-1:0] dataByte,
  output logic              colLoad,
  output logic [COL_W-1:0]  colStart,
  output logic [COL_W-1:0]  colEnd,
  output logic              rowLoad,
  output logic [ROW_W-1:0]  rowStart,
  output logic [ROW_W-1:0]  rowEnd,
  output logic              remapLoad,
  output logic [BYTE_W-1:0] remapVal,
  output logic              errPulse,
  output logic [BYTE_W-1:0] errOpcode
);
  logic [BYTE_W-1:0] firstArg;

  function automatic logic [COL_W-1:0] foldCol(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] m;
    m = v % BYTE_W'(COL_SPAN);
    return m[COL_W-1:0];
  endfunction

  function automatic logic [ROW_W-1:0] foldRow(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] m;
    m = v % BYTE_W'(ROW_SPAN);
    return m[ROW_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcodeQ    <= '0;
      firstArg   <= '0;
      dataStrobe <= 1'b0;
      dataByte   <= '0;
      colLoad    <= 1'b0;
      colStart   <= '0;
      colEnd     <= COL_W'(COL_SPAN - 1);
      rowLoad    <= 1'b0;
      rowStart   <= '0;
      rowEnd     <= ROW_W'(ROW_SPAN - 1);
      remapLoad  <= 1'b0;
      remapVal   <= '0;
      errPulse   <= 1'b0;
      errOpcode  <= '0;
    end else begin
      dataStrobe <= ctl.passData;
      colLoad    <= ctl.fireCol;
      rowLoad    <= ctl.fireRow;
      remapLoad  <= ctl.fireRemap;
      errPulse   <= ctl.fireErr;
      if (ctl.passData)   dataByte <= byteIn;
      if (ctl.captureOp)  opcodeQ  <= byteIn;
      if (ctl.captureOp)  firstArg <= '0;
      if (ctl.captureArg && firstArg == '0 && opcodeQ != '0) firstArg <= byteIn;
      if (ctl.fireCol) begin
        colStart <= foldCol(firstArg);
        colEnd   <= foldCol(byteIn);
      end
      if (ctl.fireRow) begin
        rowStart <= foldRow(firstArg);
        rowEnd   <= foldRow(byteIn);
      end
      if (ctl.fireRemap) remapVal  <= byteIn;
      if (ctl.fireErr)   errOpcode <= byteIn;
    end
  end
endmodule

// File: rtl/cmd_byte_parser.sv
module cmd_byte_parser
  import cmd_byte_parser_pkg::*;
#(
  parameter int COL_SPAN = 64,
  parameter int ROW_SPAN = 80,
  localparam int COL_W = $clog2(COL_SPAN),
  localparam int ROW_W = $clog2(ROW_SPAN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic              dataSel,
  input  logic [BYTE_W-1:0] byteIn,
  output logic              dataStrobe,
  output logic [BYTE_W-1:0] dataByte,
  output logic              colLoad,
  output logic [COL_W-1:0]  colStart,
  output logic [COL_W-1:0]  colEnd,
  output logic              rowLoad,
  output logic [ROW_W-1:0]  rowStart,
  output logic [ROW_W-1:0]  rowEnd,
  output logic              remapLoad,
  output logic [BYTE_W-1:0] remapVal,
  output logic              errPulse,
  output logic [BYTE_W-1:0] errOpcode
);
  ctlStrobes_t       ctl;
  logic [BYTE_W-1:0] opcodeQ;

  cmd_byte_parser_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .dataSel(dataSel),
    .byteIn(byteIn), .opcodeQ(opcodeQ), .ctl(ctl)
  );

  cmd_byte_parser_dp #(.COL_SPAN(COL_SPAN), .ROW_SPAN(ROW_SPAN)) u_dp (
    .clk(clk), .rstN(rstN), .byteIn(byteIn), .ctl(ctl), .opcodeQ(opcodeQ),
    .dataStrobe(dataStrobe), .dataByte(dataByte),
    .colLoad(colLoad), .colStart(colStart), .colEnd(colEnd),
    .rowLoad(rowLoad), .rowStart(rowStart), .rowEnd(rowEnd),
    .remapLoad(remapLoad), .remapVal(remapVal),
    .errPulse(errPulse), .errOpcode(errOpcode)
  );
endmodule

// File: rtl/cmd_byte_parser_chk.sv
module cmd_byte_parser_chk #(
  parameter int COL_SPAN = 64,
  parameter int ROW_SPAN = 80,
  localparam int COL_W = $clog2(COL_SPAN),
  localparam int ROW_W = $clog2(ROW_SPAN)
) (
  input logic             clk,
  input logic             rstN,
  input logic             byteValid,
  input logic             dataSel,
  input logic [7:0]       byteIn,
  input logic             dataStrobe,
  input logic [7:0]       dataByte,
  input logic             colLoad,
  input logic [COL_W-1:0] colStart,
  input logic [COL_W-1:0] colEnd,
  input logic             rowLoad,
  input logic [ROW_W-1:0] rowStart,
  input logic [ROW_W-1:0] rowEnd,
  input logic             remapLoad,
  input logic             errPulse
);
  p_data_pass_r1: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && dataSel) |=> (dataStrobe && dataByte == $past(byteIn)));

  p_col_from_cmd_r2: assert property (@(posedge clk) disable iff (!rstN)
    colLoad |-> $past(byteValid && !dataSel));

  p_row_bounds_r3: assert property (@(posedge clk) disable iff (!rstN)
    (32'(rowStart) < ROW_SPAN) && (32'(rowEnd) < ROW_SPAN));

  p_col_bounds_r2: assert property (@(posedge clk) disable iff (!rstN)
    (32'(colStart) < COL_SPAN) && (32'(colEnd) < COL_SPAN));

  p_err_from_cmd_r8: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(byteValid && !dataSel));

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dataStrobe, colLoad, rowLoad, remapLoad, errPulse}));
endmodule

bind cmd_byte_parser cmd_byte_parser_chk #(.COL_SPAN(COL_SPAN), .ROW_SPAN(ROW_SPAN)) u_chk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .dataSel(dataSel), .byteIn(byteIn),
  .dataStrobe(dataStrobe), .dataByte(dataByte), .colLoad(colLoad), .colStart(colStart),
  .colEnd(colEnd), .rowLoad(rowLoad), .rowStart(rowStart), .rowEnd(rowEnd),
  .remapLoad(remapLoad), .errPulse(errPulse)
);

// File: tb/cmd_byte_parser_tb.sv
`timescale 1ns/1ps
module cmd_byte_parser_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0;
  logic dataSel = 1'b0;
  logic [7:0] byteIn = '0;
  logic dataStrobe, colLoad, rowLoad, remapLoad, errPulse;
  logic [7:0] dataByte, remapVal, errOpcode;
  logic [5:0] colStart, colEnd;
  logic [6:0] rowStart, rowEnd;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cmd_byte_parser u_dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .dataSel(dataSel), .byteIn(byteIn),
    .dataStrobe(dataStrobe), .dataByte(dataByte), .colLoad(colLoad), .colStart(colStart),
    .colEnd(colEnd), .rowLoad(rowLoad), .rowStart(rowStart), .rowEnd(rowEnd),
    .remapLoad(remapLoad), .remapVal(remapVal), .errPulse(errPulse), .errOpcode(errOpcode)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one byte in, outputs sampled at the following falling edge
  task automatic put(input bit sel, input logic [7:0] b);
    byteValid = 1'b1; dataSel = sel; byteIn = b;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  function automatic int strobes();
    return {27'd0, dataStrobe, colLoad, rowLoad, remapLoad, errPulse};
  endfunction

  task automatic t_reset();
    check("R10 strobes", strobes(), 0);
    check("R10 colStart", colStart, 0);
    check("R10 colEnd", colEnd, 63);
    check("R10 rowStart", rowStart, 0);
    check("R10 rowEnd", rowEnd, 79);
    check("R10 remapVal", remapVal, 0);
  endtask

  task automatic t_data();
    put(1'b1, 8'h5C);
    check("R1 strobe", strobes(), 16);
    check("R1 byte", dataByte, 8'h5C);
    @(negedge clk);
    check("R1 one cycle", strobes(), 0);
  endtask

  task automatic t_col();
    put(1'b0, 8'h15); put(1'b0, 8'd7);
    check("R2 no early load", strobes(), 0);
    put(1'b0, 8'd100);
    check("R2 load", strobes(), 8);
    check("R2 start", colStart, 7);
    check("R2 end fold", colEnd, 100 % 64);
    put(1'b0, 8'h15); put(1'b0, 8'hFF); put(1'b0, 8'h40);
    check("R2 start fold", colStart, 255 % 64);
    check("R2 end zero", colEnd, 0);
  endtask

  task automatic t_row_interleave();
    put(1'b0, 8'h75); put(1'b0, 8'd85);
    put(1'b1, 8'hAB);
    check("R9 data mid-command", strobes(), 16);
    put(1'b0, 8'd200);
    check("R9 row resumes", strobes(), 4);
    check("R3 start fold", rowStart, 85 % 80);
    check("R3 end fold", rowEnd, 200 % 80);
  endtask

  task automatic t_remap_and_skips();
    put(1'b0, 8'h81); put(1'b0, 8'h15);
    check("R5 arg swallowed", strobes(), 0);
    put(1'b0, 8'hA0); put(1'b0, 8'h3C);
    check("R5 next is opcode", strobes(), 2);
    check("R4 remap value", remapVal, 8'h3C);
    put(1'b0, 8'hA4); put(1'b0, 8'hE3); put(1'b0, 8'hFF);
    check("R6 no strobe", strobes(), 0);
    put(1'b0, 8'hA0); put(1'b0, 8'h71);
    check("R6 next is opcode", remapVal, 8'h71);
  endtask

  task automatic t_gray();
    put(1'b0, 8'hB8);
    put(1'b0, 8'hA0); put(1'b0, 8'h11); put(1'b0, 8'h15); put(1'b0, 8'h01);
    put(1'b0, 8'h02); put(1'b0, 8'hA0); put(1'b0, 8'h22);
    check("R7 seven args swallowed", remapVal, 8'h71);
    put(1'b0, 8'h33);
    check("R7 eighth swallowed", strobes(), 0);
    put(1'b0, 8'hA0); put(1'b0, 8'h44);
    check("R7 after eight", remapVal, 8'h44);
  endtask

  task automatic t_unknown();
    put(1'b0, 8'h12);
    check("R8 err pulse", strobes(), 1);
    check("R8 opcode", errOpcode, 8'h12);
    @(negedge clk);
    check("R8 one cycle", errPulse, 0);
    put(1'b0, 8'hA0); put(1'b0, 8'h5A);
    check("R8 complete", remapVal, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_data();
    t_col();
    t_row_interleave();
    t_remap_and_skips();
    t_gray();
    t_unknown();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule